// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces one column address per data beat of a memory burst. A single-cycle start pulse carries the column at which the burst begins, together with a length code and an ordering select. From the next cycle onward, the sequencer presents one column per clock. With each column it raises a valid flag, and it marks the final beat of a burst of fixed length.

Fixed-length bursts stay inside the aligned block whose size equals the burst length. Within that block the low column bits either count upward with wrap-around or follow an XOR pattern against the beat index. The upper bits do not change. A full-row burst steps through every column of the 512-column row and wraps from the top column back to zero. It never ends by itself, so only a terminate strobe or a new start stops it. A new start pulse may arrive in any cycle. It replaces the running burst, and the new burst's first column appears on the very next beat.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after its release with no start pulse, `beat_vld_o`, `last_o` and `illegal_o` are low.
- R2: A start pulse registered at a clock edge makes the next cycle a valid beat whose column equals the start column. The beat is valid in the cycle directly after the pulse.
- R3: Length codes are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8, and 7 for a full row. In sequential order (`ilv_i` low), the low log2(BL) column bits count upward from the start offset and wrap inside the aligned block of BL columns. The upper bits keep the start value, and beats follow on consecutive cycles.
- R4: In interleaved order (`ilv_i` high) with a fixed length, the low log2(BL) column bits of beat k equal the start offset XOR k. For a 4-beat burst, start offset 2 gives 2,3,0,1 and start offset 3 gives 3,2,1,0.
- R5: `last_o` is high on beat BL-1 of a fixed-length burst and only on a valid beat. In the cycle after the last beat, `beat_vld_o` is low unless a new start was given.
- R6: A burst of length 1 yields exactly one beat, at the start column, with `last_o` high.
- R7: A full-row burst increments the column by one on every beat and wraps from 511 to 0. It never raises `last_o` and stays valid for as long as neither terminate nor start arrives.
- R8: A full-row burst requested with interleaved order raises `illegal_o` on each of its beats and runs in sequential order. All other bursts keep `illegal_o` low.
- R9: A terminate strobe without a start pulse makes the following cycle invalid. When a terminate strobe and a start pulse arrive together, the start pulse takes precedence.
- R10: A start pulse during a running burst cuts that burst short, and the next beat is the new start column under the new length and order.
- R11: Unused length codes 4, 5 and 6 act as a burst of length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | 9 | Column at which the burst begins |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| term_i | input | 1 | Terminate strobe that stops the running burst |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | Current cycle carries a beat |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |
| illegal_o | output | 1 | Current burst is a full-row request with interleaved order |

## Verification
The hardest case to reach is the full-row wrap that happens long after the start. It occurs only after hundreds of beats with no start and no terminate, and at that point `last_o` must still be low. The bench starts a full-row burst three columns below the top of the row, watches the burst cross column 0, and then keeps it running for 600 more cycles before it checks the column and terminates. Restart and terminate collisions are hit by driving the next start pulse or strobe in the middle of a running burst.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned COL_W   = 9;
  localparam int unsigned CODE_W  = 3;

  // burst length codes
  localparam logic [CODE_W-1:0] LEN_1   = 3'd0;
  localparam logic [CODE_W-1:0] LEN_2   = 3'd1;
  localparam logic [CODE_W-1:0] LEN_4   = 3'd2;
  localparam logic [CODE_W-1:0] LEN_8   = 3'd3;
  localparam logic [CODE_W-1:0] LEN_ROW = 3'd7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = bcs_pkg::COL_W,
  parameter int unsigned CODE_W = bcs_pkg::CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ilv_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output logic              ilv_eff_o,
  output logic              illegal_o
);
  localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

  always_comb begin
    full_o = 1'b0;
    unique case (code_i)
      LEN_2:   mask_o = COL_W'(1);
      LEN_4:   mask_o = COL_W'(3);
      LEN_8:   mask_o = COL_W'(7);
      LEN_ROW: begin
        mask_o = ONES;
        full_o = 1'b1;
      end
      default: mask_o = '0;   // length 1 and unused codes
    endcase
  end

  // interleaving is refused for full-row bursts
  assign illegal_o = full_o & ilv_i;
  assign ilv_eff_o = ilv_i & ~full_o;
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             illegal_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             illegal_o
);
  seq_state_e       state_q, state_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ld_en;
  logic [COL_W-1:0] base_q, mask_q;
  logic             full_q, ilv_q, illegal_q;
  logic             at_end;

  assign at_end = ~full_q & (cnt_q == mask_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    ld_en   = 1'b0;
    if (start_i) begin
      state_d = ST_RUN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
      ld_en   = 1'b1;
    end else if (term_i) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_RUN) begin
      if (at_end) begin
        state_d = ST_IDLE;
      end else begin
        cnt_d  = cnt_q + COL_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else if (ld_en) begin
      base_q    <= start_col_i;
      mask_q    <= mask_i;
      full_q    <= full_i;
      ilv_q     <= ilv_i;
      illegal_q <= illegal_i;
    end
  end

  assign active_o  = (state_q == ST_RUN);
  assign last_o    = active_o & at_end;
  assign base_o    = base_q;
  assign cnt_o     = cnt_q;
  assign mask_o    = mask_q;
  assign full_o    = full_q;
  assign ilv_o     = ilv_q;
  assign illegal_o = active_o & illegal_q;
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;

  // carries from the low bits only reach masked positions above them
  assign sum = base_i + cnt_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic moving;
    assign moving   = ilv_i ? (base_i[b] ^ cnt_i[b]) : sum[b];
    assign col_o[b] = mask_i[b] ? moving : base_i[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = bcs_pkg::COL_W,
  parameter int unsigned CODE_W = bcs_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] blen_i,
  input  logic              ilv_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_vld_o,
  output logic              last_o,
  output logic              illegal_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_ilv, dec_illegal;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             full_q, ilv_q;

  bcs_mode_decode #(.COL_W(COL_W), .CODE_W(CODE_W)) u_dec (
    .code_i    (blen_i),
    .ilv_i     (ilv_i),
    .mask_o    (dec_mask),
    .full_o    (dec_full),
    .ilv_eff_o (dec_ilv),
    .illegal_o (dec_illegal)
  );

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (dec_ilv),
    .illegal_i   (dec_illegal),
    .active_o    (beat_vld_o),
    .last_o      (last_o),
    .base_o      (base_q),
    .cnt_o       (cnt_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .ilv_o       (ilv_q),
    .illegal_o   (illegal_o)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int unsigned COL_W = bcs_pkg::COL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             last_o,
  input logic             illegal_o,
  input logic             full_i
);
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> beat_vld_o && (col_o == $past(start_col_i)));

  a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_vld_o);

  a_r5_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i && !term_i |=> !beat_vld_o);

  a_r3_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && !last_o && !start_i && !term_i |=> beat_vld_o);

  a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    term_i && !start_i |=> !beat_vld_o);

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && full_i && !start_i && !term_i
      |=> beat_vld_o && (col_o == COL_W'($past(col_o) + COL_W'(1))));

  a_r7_never_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld_o && full_i |-> !last_o);

  a_r8_illegal_row: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> beat_vld_o && full_i);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .beat_vld_o  (beat_vld_o),
  .last_o      (last_o),
  .illegal_o   (illegal_o),
  .full_i      (full_q)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, ilv_i, term_i;
  logic [8:0] start_col_i;
  logic [2:0] blen_i;
  logic [8:0] col_o;
  logic       beat_vld_o, last_o, illegal_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  burst_col_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .term_i(term_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [8:0] col;
    logic [2:0] code;
    logic       ilv;
    logic [3:0] n;
    logic [8:0] e0, e1, e2, e3;
  } vec_t;

  // R3 sequential wrap, R4 interleaved order, R6 length 1, R11 unused code
  localparam vec_t VECS [9] = '{
    '{9'h005, 3'd2, 1'b0, 4'd4, 9'h005, 9'h006, 9'h007, 9'h004},
    '{9'h0FE, 3'd3, 1'b0, 4'd8, 9'h0FE, 9'h0FF, 9'h0F8, 9'h0F9},
    '{9'h006, 3'd2, 1'b1, 4'd4, 9'h006, 9'h007, 9'h004, 9'h005},
    '{9'h013, 3'd2, 1'b1, 4'd4, 9'h013, 9'h012, 9'h011, 9'h010},
    '{9'h00D, 3'd3, 1'b1, 4'd8, 9'h00D, 9'h00C, 9'h00F, 9'h00E},
    '{9'h1FF, 3'd1, 1'b0, 4'd2, 9'h1FF, 9'h1FE, 9'h000, 9'h000},
    '{9'h101, 3'd1, 1'b1, 4'd2, 9'h101, 9'h100, 9'h000, 9'h000},
    '{9'h100, 3'd0, 1'b0, 4'd1, 9'h100, 9'h000, 9'h000, 9'h000},
    '{9'h021, 3'd5, 1'b1, 4'd1, 9'h021, 9'h000, 9'h000, 9'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic kick(input logic [8:0] c, input logic [2:0] code, input logic il);
    start_i = 1'b1; start_col_i = c; blen_i = code; ilv_i = il;
    step();
    start_i = 1'b0;
  endtask

  function automatic logic [8:0] pick(input vec_t v, input int i);
    case (i)
      0: return v.e0;
      1: return v.e1;
      2: return v.e2;
      default: return v.e3;
    endcase
  endfunction

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic saw_last;
    rst_n = 1'b0; start_i = 1'b0; term_i = 1'b0; ilv_i = 1'b0;
    start_col_i = '0; blen_i = '0;
    repeat (3) step();
    chk("R1 vld in reset", beat_vld_o, 0);
    rst_n = 1'b1;
    step();
    chk("R1 vld after reset", beat_vld_o, 0);
    chk("R1 last after reset", last_o, 0);
    chk("R1 illegal after reset", illegal_o, 0);

    // vector table
    for (int v = 0; v < 9; v++) begin
      kick(VECS[v].col, VECS[v].code, VECS[v].ilv);
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        chk($sformatf("R2/R3 vec %0d beat %0d vld", v, i), beat_vld_o, 1);
        if (i < 4) chk($sformatf("R3/R4/R6/R11 vec %0d beat %0d col", v, i), col_o, pick(VECS[v], i));
        chk($sformatf("R5/R6 vec %0d beat %0d last", v, i), last_o, (i == int'(VECS[v].n) - 1));
        chk($sformatf("R8 vec %0d beat %0d illegal", v, i), illegal_o, 0);
        step();
      end
      chk($sformatf("R5 vec %0d idle after last", v), beat_vld_o, 0);
      step();
    end

    // R7 full row from near the top of the row
    kick(9'h1FD, 3'd7, 1'b0);
    chk("R7 col 1FD", col_o, 9'h1FD); step();
    chk("R7 col 1FE", col_o, 9'h1FE); step();
    chk("R7 col 1FF", col_o, 9'h1FF); step();
    chk("R7 wrap to 0", col_o, 9'h000);
    chk("R7 vld at wrap", beat_vld_o, 1); step();
    chk("R7 col 001", col_o, 9'h001);
    saw_last = 1'b0;
    for (int k = 0; k < 600; k++) begin
      step();
      if (last_o) saw_last = 1'b1;
    end
    chk("R7 no last in row burst", saw_last, 0);
    chk("R7 still valid", beat_vld_o, 1);
    chk("R7 col after 600 beats", col_o, 9'h059);
    term_i = 1'b1; step(); term_i = 1'b0;
    chk("R9 term ends row burst", beat_vld_o, 0);
    step();

    // R8 full row with interleave request
    kick(9'h00A, 3'd7, 1'b1);
    chk("R8 illegal flag", illegal_o, 1);
    chk("R8 col 00A", col_o, 9'h00A); step();
    chk("R8 sequential 00B", col_o, 9'h00B); step();
    chk("R8 sequential 00C", col_o, 9'h00C);
    chk("R8 illegal held", illegal_o, 1);
    term_i = 1'b1; step(); term_i = 1'b0;
    chk("R9 term vld", beat_vld_o, 0);
    chk("R8 illegal clears", illegal_o, 0);

    // R10 restart in the middle of a burst
    kick(9'h040, 3'd3, 1'b0);
    chk("R10 first col", col_o, 9'h040); step();
    chk("R10 second col", col_o, 9'h041);
    kick(9'h083, 3'd2, 1'b0);
    chk("R10 new start col", col_o, 9'h083); step();
    chk("R10 new wrap col", col_o, 9'h080); step();
    chk("R10 col 081", col_o, 9'h081); step();
    chk("R10 col 082", col_o, 9'h082);
    chk("R10 last of new burst", last_o, 1); step();
    chk("R10 idle after", beat_vld_o, 0);

    // R9 terminate in the middle of a fixed burst
    kick(9'h000, 3'd3, 1'b0);
    step(); step();
    term_i = 1'b1; step(); term_i = 1'b0;
    chk("R9 term mid burst vld", beat_vld_o, 0);
    chk("R9 term mid burst last", last_o, 0);

    // R9 start and terminate together: start wins
    kick(9'h010, 3'd3, 1'b0);
    step();
    term_i = 1'b1;
    kick(9'h1C2, 3'd2, 1'b1);
    term_i = 1'b0;
    chk("R9 start beats term vld", beat_vld_o, 1);
    chk("R9 start beats term col", col_o, 9'h1C2); step();
    chk("R9/R4 next interleaved col", col_o, 9'h1C3);
    step(); step(); step();
    chk("R5 idle", beat_vld_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule